// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port with Register Readback

This block is the configuration front end of a synthesizer control section. A host shifts 32-bit frames in on a serial clock and data line, framed by a load-enable strobe. The three low bits of each frame pick a target and the upper 29 bits carry its contents. Five targets are writable control words. A sixth target is a read-only status word that reports a power-on marker and the result of an on-chip converter. The control words appear in parallel on output ports for the rest of the chip.

Any register can be read back on a single serial output. To do this the host sets the output-select field of control word 0 to readback mode, then sends a frame with its top bit set. Such a frame changes no register. Its contents are then shifted out, top bit first, on the following serial clock edges. The reference-divider and modulus fields in control words 1 and 2 are double-buffered. A write parks them in pending storage, and they reach the outputs only when control word 0 is written, so a multi-word retune takes effect all at once.

The serial pins are synchronized into the system clock domain and their edges are detected there. The serial clock must therefore stay high and low for several system clock periods.

Top module: `serial_regif`

## Requirements
- R1: On each rising serial clock edge while load-enable is low, the data pin is shifted in, most significant bit first. On the rising edge of load-enable, a frame with bit 31 clear writes frame bits 31:3 to the register addressed by frame bits 2:0 (0 to 4). The register then shows on its cfgN_o port, with port bit 0 holding frame bit 3.
- R2: A frame takes effect only if exactly 32 serial clock rises happened since load-enable last fell. With 31 or 33 rises the load-enable edge does nothing.
- R3: Frames addressed to 5 or 7 change no state. A write addressed to 6 leaves the status word unchanged.
- R4: A frame with bit 31 set (read request) modifies no register, whatever frame bits 30:3 hold.
- R5: A read request starts readback only when frame bits 30:27 of register 0 (cfg0_o bits 27:24) equal 0111. After load-enable rises, ser_out_o is low. The addressed word's bit 31 shows after the 1st rising serial clock edge, and its bit 3 after the 29th. The output is low again after the 30th.
- R6: When readback mode is not selected, a read request leaves ser_out_o low throughout.
- R7: Register 1 frame bits 19:15 and register 2 frame bits 21:15 and 14:3 are double-buffered. A write to them is held pending and reaches cfg1_o and cfg2_o only on the next write to register 0. The other bits of registers 1 and 2 update at once. Readback returns the last written value, pending bits included.
- R8: Status word address 6 reads back frame bit 11 as a power-on flag, frame bit 10 as stat_vld_i and frame bits 9:3 as stat_code_i. The power-on flag is 1 after reset and is cleared once a readback of address 6 has started.
- R9: After reset, all cfgN_o ports are zero and ser_out_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data in |
| ser_le_i | input | 1 | Load-enable strobe; frame latched on rising edge |
| stat_vld_i | input | 1 | Converter result valid, reported in the status word |
| stat_code_i | input | 7 | Converter result, reported in the status word |
| ser_out_o | output | 1 | Serial readback output |
| cfg0_o | output | 29 | Control word 0 (frame bits 31:3) |
| cfg1_o | output | 29 | Control word 1, buffered fields as committed |
| cfg2_o | output | 29 | Control word 2, buffered fields as committed |
| cfg3_o | output | 29 | Control word 3 |
| cfg4_o | output | 29 | Control word 4 |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a 7-bit converter code. The serial half period is four system clocks, which leaves room for synchronizer latency. This lets the bench clock exact frame lengths of 31, 32 and 33 bits and so reach the frame-length gate on both sides. A 7-bit code fills the status word up to the power-on flag in bit 11, so the flag, the valid bit and every code bit are checked in one readback.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;
  localparam int FRAME_W  = 32;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = FRAME_W - ADDR_W;
  localparam int NUM_RW   = 5;
  localparam int READ_BIT = DATA_W - 1;
  localparam int SEL_W    = 4;
  localparam int SEL_LSB  = 27 - ADDR_W;

  localparam logic [ADDR_W-1:0] STAT_ADDR    = 3'd6;
  localparam logic [SEL_W-1:0]  SEL_READBACK = 4'b0111;

  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // bits that commit only on a register 0 write, per register, data-aligned
  localparam data_t BUF_MASK [NUM_RW] = '{
    29'h0000000, 29'h001F000, 29'h007FFFF, 29'h0000000, 29'h0000000
  };
endpackage

// File: rtl/serial_regif_sync.sv
module serial_regif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q, ff_d;

  always_comb ff_d = {ff_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_regif_rx.sv
module serial_regif_rx
  import serial_regif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_rise_i,
  input  logic   le_rise_i,
  input  logic   le_fall_i,
  input  logic   le_lvl_i,
  input  logic   dat_i,
  output logic   frm_vld_o,
  output frame_t frm_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  frame_t           sh_q, sh_d;
  logic             vld_q, vld_d;
  logic             shift_en;

  always_comb begin
    shift_en = sclk_rise_i & ~le_lvl_i;
    sh_d     = shift_en ? {sh_q[FRAME_W-2:0], dat_i} : sh_q;
    cnt_d    = cnt_q;
    if (le_fall_i)
      cnt_d = '0;
    else if (shift_en && (cnt_q != CNT_W'(CNT_MAX)))
      cnt_d = cnt_q + 1'b1;
    vld_d = le_rise_i && (cnt_q == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign frm_vld_o = vld_q;
  assign frm_o     = sh_q;
endmodule

// File: rtl/serial_regif_bank.sv
module serial_regif_bank
  import serial_regif_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frm_vld_i,
  input  frame_t                       frm_i,
  input  logic                         stat_vld_i,
  input  logic [CODE_W-1:0]            stat_code_i,
  output logic [NUM_RW-1:0][DATA_W-1:0] cfg_o,
  output logic                         rd_start_o,
  output data_t                        rd_word_o
);
  logic [ADDR_W-1:0]             addr;
  data_t                         wdat;
  logic                          is_rd;
  logic [NUM_RW-1:0]             wr_en;
  logic [NUM_RW-1:0][DATA_W-1:0] pend_all;

  assign addr  = frm_i[ADDR_W-1:0];
  assign wdat  = frm_i[FRAME_W-1:ADDR_W];
  assign is_rd = wdat[READ_BIT];

  for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
    data_t pend_q, pend_d;

    assign wr_en[i] = frm_vld_i & ~is_rd & (addr == ADDR_W'(i));

    always_comb pend_d = wr_en[i] ? wdat : pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
    end

    assign pend_all[i] = pend_q;

    if (BUF_MASK[i] != '0) begin : g_buf
      data_t act_q, act_d;

      always_comb act_d = wr_en[0] ? (pend_q & BUF_MASK[i]) : act_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
      end

      assign cfg_o[i] = (pend_q & ~BUF_MASK[i]) | act_q;
    end else begin : g_direct
      assign cfg_o[i] = pend_q;
    end
  end

  logic  por_q, por_d;
  logic  sel_ok, addr_ok, start_d, start_q;
  data_t stat_word, rd_src, word_q, word_d;

  assign stat_word = DATA_W'({por_q, stat_vld_i, stat_code_i});
  assign sel_ok    = (pend_all[0][SEL_LSB +: SEL_W] == SEL_READBACK);

  always_comb begin
    addr_ok = 1'b0;
    rd_src  = '0;
    for (int k = 0; k < NUM_RW; k++) begin
      if (addr == ADDR_W'(k)) begin
        addr_ok = 1'b1;
        rd_src  = pend_all[k];
      end
    end
    if (addr == STAT_ADDR) begin
      addr_ok = 1'b1;
      rd_src  = stat_word;
    end
    start_d = frm_vld_i & is_rd & sel_ok & addr_ok;
    word_d  = start_d ? rd_src : word_q;
    por_d   = (start_d && (addr == STAT_ADDR)) ? 1'b0 : por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q   <= 1'b1;
      start_q <= 1'b0;
      word_q  <= '0;
    end else begin
      por_q   <= por_d;
      start_q <= start_d;
      word_q  <= word_d;
    end
  end

  assign rd_start_o = start_q;
  assign rd_word_o  = word_q;
endmodule

// File: rtl/serial_regif_rb.sv
module serial_regif_rb
  import serial_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  data_t word_i,
  input  logic  sclk_rise_i,
  output logic  out_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  data_t            sh_q, sh_d;
  logic             out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    out_d = out_q;
    if (start_i) begin
      cnt_d = CNT_W'(DATA_W);
      sh_d  = word_i;
      out_d = 1'b0;
    end else if (sclk_rise_i) begin
      if (cnt_q != '0) begin
        out_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        cnt_d = cnt_q - 1'b1;
      end else begin
        out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  input  logic              stat_vld_i,
  input  logic [CODE_W-1:0] stat_code_i,
  output logic              ser_out_o,
  output logic [DATA_W-1:0] cfg0_o,
  output logic [DATA_W-1:0] cfg1_o,
  output logic [DATA_W-1:0] cfg2_o,
  output logic [DATA_W-1:0] cfg3_o,
  output logic [DATA_W-1:0] cfg4_o
);
  localparam int          NUM_PINS = 3;
  localparam logic [2:0]  PIN_RST  = 3'b100;

  logic rst_sn;

  serial_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sn)
  );

  logic [NUM_PINS-1:0] pin_raw, pin_s;
  assign pin_raw = {ser_le_i, ser_clk_i, ser_dat_i};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    serial_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[p])) u_sync (
      .clk(clk), .rst_n(rst_sn), .d_i(pin_raw[p]), .q_o(pin_s[p])
    );
  end

  logic dat_s, sclk_s, le_s;
  logic sclk_d_q, le_d_q;
  logic sclk_rise, le_rise, le_fall;

  assign {le_s, sclk_s, dat_s} = pin_s;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_d_q <= 1'b0;
      le_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s;
      le_d_q   <= le_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign le_rise   = le_s & ~le_d_q;
  assign le_fall   = ~le_s & le_d_q;

  logic   frm_vld;
  frame_t frm_word;

  serial_regif_rx u_rx (
    .clk(clk), .rst_n(rst_sn), .sclk_rise_i(sclk_rise), .le_rise_i(le_rise),
    .le_fall_i(le_fall), .le_lvl_i(le_s), .dat_i(dat_s),
    .frm_vld_o(frm_vld), .frm_o(frm_word)
  );

  logic [NUM_RW-1:0][DATA_W-1:0] cfg_arr;
  logic  rd_start;
  data_t rd_word;

  serial_regif_bank #(.CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_sn), .frm_vld_i(frm_vld), .frm_i(frm_word),
    .stat_vld_i(stat_vld_i), .stat_code_i(stat_code_i),
    .cfg_o(cfg_arr), .rd_start_o(rd_start), .rd_word_o(rd_word)
  );

  serial_regif_rb u_rb (
    .clk(clk), .rst_n(rst_sn), .start_i(rd_start), .word_i(rd_word),
    .sclk_rise_i(sclk_rise), .out_o(ser_out_o)
  );

  assign cfg0_o = cfg_arr[0];
  assign cfg1_o = cfg_arr[1];
  assign cfg2_o = cfg_arr[2];
  assign cfg3_o = cfg_arr[3];
  assign cfg4_o = cfg_arr[4];
endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk
  import serial_regif_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frm_vld,
  input frame_t                     frm,
  input logic                       rd_start,
  input logic                       sclk_rise,
  input logic                       ser_out,
  input logic [NUM_RW*DATA_W-1:0]   cfg_flat
);
  logic [5:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rise_cnt <= 6'd63;
    else if (rd_start)                    rise_cnt <= 6'd0;
    else if (sclk_rise && rise_cnt != 6'd63) rise_cnt <= rise_cnt + 6'd1;
  end

  // R3
  rsvd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && (frm[2:0] == 3'd5 || frm[2:0] == 3'd7) |=> $stable(cfg_flat));

  // R4
  read_nomod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && frm[FRAME_W-1] |=> $stable(cfg_flat));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_vld && !frm[FRAME_W-1] && frm[2:0] == 3'd0) |=>
      $stable(cfg_flat[DATA_W +: DATA_W] & BUF_MASK[1]) &&
      $stable(cfg_flat[2*DATA_W +: DATA_W] & BUF_MASK[2]));

  // R5
  rb_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !ser_out);

  // R6
  rb_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise && !rd_start && (rise_cnt >= 6'(DATA_W)) |=> !ser_out);
endmodule

bind serial_regif serial_regif_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .frm_vld(frm_vld), .frm(frm_word),
  .rd_start(rd_start), .sclk_rise(sclk_rise), .ser_out(ser_out_o),
  .cfg_flat(cfg_arr)
);

// File: tb/serial_regif_tb.sv
module serial_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NVEC       = 8;

  // {data[28:0], addr[2:0]}: expected cfg of addr equals data
  localparam logic [31:0] VEC [NVEC] = '{
    {29'h0ABCDEF1, 3'd3}, {29'h05A5A5A5, 3'd4}, {29'h01234567, 3'd0},
    {29'h0FFFFFFF, 3'd3}, {29'h0E000FFF, 3'd1}, {29'h0F380000, 3'd2},
    {29'h00000000, 3'd4}, {29'h00000000, 3'd0}
  };

  logic clk, rst_n, ser_clk, ser_dat, ser_le, stat_vld;
  logic [6:0]  stat_code;
  logic        ser_out;
  logic [28:0] cfg0, cfg1, cfg2, cfg3, cfg4;
  int nchk, nerr;
  bit done;

  serial_regif u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_le_i(ser_le), .stat_vld_i(stat_vld), .stat_code_i(stat_code),
    .ser_out_o(ser_out), .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2),
    .cfg3_o(cfg3), .cfg4_o(cfg4)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] cfg_of(input logic [2:0] a);
    case (a)
      3'd0: return cfg0;
      3'd1: return cfg1;
      3'd2: return cfg2;
      3'd3: return cfg3;
      default: return cfg4;
    endcase
  endfunction

  task automatic send_raw(input logic [63:0] w, input int n);
    ser_le = 1'b0;
    tick(HALF);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = w[b];
      tick(HALF);
      ser_clk = 1'b1;
      tick(HALF);
      ser_clk = 1'b0;
    end
    tick(HALF);
    ser_le = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic wr(input logic [2:0] a, input logic [28:0] d);
    send_raw({32'h0, d, a}, 32);
  endtask

  task automatic rd(input logic [2:0] a, output logic [28:0] got,
                    output logic first, output logic tail);
    send_raw({32'h0, 1'b1, 28'h0, a}, 32);
    first = ser_out;
    for (int i = 0; i < 29; i++) begin
      ser_clk = 1'b1;
      tick(HALF);
      got[28 - i] = ser_out;
      ser_clk = 1'b0;
      tick(HALF);
    end
    ser_clk = 1'b1;
    tick(HALF);
    tail = ser_out;
    ser_clk = 1'b0;
    tick(HALF);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [28:0] got;
    logic first, tail;
    logic [144:0] snap;
    nchk = 0; nerr = 0; done = 1'b0;
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b1;
    stat_vld = 1'b1; stat_code = 7'h55;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R9 reset state
    check("R9 cfg0", {3'b0, cfg0}, 32'h0);
    check("R9 cfg1", {3'b0, cfg1}, 32'h0);
    check("R9 cfg2", {3'b0, cfg2}, 32'h0);
    check("R9 cfg3", {3'b0, cfg3}, 32'h0);
    check("R9 cfg4", {3'b0, cfg4}, 32'h0);
    check("R9 ser_out", {31'h0, ser_out}, 32'h0);

    // R1 table of writes, MSB first, direct bits only
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][2:0], VEC[k][31:3]);
      check($sformatf("R1 vec%0d", k), {3'b0, cfg_of(VEC[k][2:0])}, {3'b0, VEC[k][31:3]});
    end

    // R7 double-buffered fields
    wr(3'd2, 29'h00012ABC);
    check("R7 cfg2 pending", {3'b0, cfg2}, 32'h0);
    wr(3'd1, 29'h0001F000);
    check("R7 cfg1 pending", {3'b0, cfg1}, 32'h0);
    wr(3'd0, 29'h07000000);
    check("R7 cfg2 commit", {3'b0, cfg2}, 32'h00012ABC);
    check("R7 cfg1 commit", {3'b0, cfg1}, 32'h0001F000);
    check("R1 cfg0 sel", {3'b0, cfg0}, 32'h07000000);

    // R5 readback of register 2 and 3
    rd(3'd2, got, first, tail);
    check("R5 start low", {31'h0, first}, 32'h0);
    check("R5 rd2 word", {3'b0, got}, 32'h00012ABC);
    check("R5 rd2 tail", {31'h0, tail}, 32'h0);
    wr(3'd2, 29'h00000001);
    rd(3'd2, got, first, tail);
    check("R7 rd pending", {3'b0, got}, 32'h00000001);
    check("R7 cfg2 held", {3'b0, cfg2}, 32'h00012ABC);
    rd(3'd3, got, first, tail);
    check("R5 rd3 word", {3'b0, got}, 32'h0FFFFFFF);
    check("R5 rd3 tail", {31'h0, tail}, 32'h0);

    // R4 read frames leave registers alone
    check("R4 cfg3 after read", {3'b0, cfg3}, 32'h0FFFFFFF);
    send_raw({32'h0, 1'b1, 28'hABCDEF0, 3'd4}, 32);
    check("R4 cfg4 garbage read", {3'b0, cfg4}, 32'h0);

    // R8 status word and power-on flag
    rd(3'd6, got, first, tail);
    check("R8 status first", {3'b0, got}, 32'h000001D5);
    rd(3'd6, got, first, tail);
    check("R8 status flag cleared", {3'b0, got}, 32'h000000D5);
    stat_vld = 1'b0; stat_code = 7'h2A;
    rd(3'd6, got, first, tail);
    check("R8 status inputs", {3'b0, got}, 32'h0000002A);

    // R3 reserved addresses and read-only target
    snap = {cfg0, cfg1, cfg2, cfg3, cfg4};
    wr(3'd5, 29'h0FFFFFFF);
    check("R3 addr5", {cfg0, cfg1, cfg2, cfg3, cfg4} == snap ? 32'h1 : 32'h0, 32'h1);
    wr(3'd7, 29'h0FFFFFFF);
    check("R3 addr7", {cfg0, cfg1, cfg2, cfg3, cfg4} == snap ? 32'h1 : 32'h0, 32'h1);
    wr(3'd6, 29'h0FFFFFFF);
    check("R3 addr6 write", {cfg0, cfg1, cfg2, cfg3, cfg4} == snap ? 32'h1 : 32'h0, 32'h1);
    rd(3'd6, got, first, tail);
    check("R3 status unchanged", {3'b0, got}, 32'h0000002A);

    // R2 frame length gate
    send_raw({32'h0, 29'h00001234, 3'd4}, 31);
    check("R2 short frame", {3'b0, cfg4}, 32'h0);
    send_raw({31'h0, 1'b0, 29'h00001234, 3'd4}, 33);
    check("R2 long frame", {3'b0, cfg4}, 32'h0);
    wr(3'd4, 29'h00001234);
    check("R2 exact frame", {3'b0, cfg4}, 32'h00001234);

    // R6 readback not selected
    wr(3'd0, 29'h0);
    rd(3'd3, got, first, tail);
    check("R6 no readback word", {3'b0, got}, 32'h0);
    check("R6 no readback tail", {31'h0, tail}, 32'h0);

    // R9 second reset restores defaults and power-on flag
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    check("R9 cfg3 after reset", {3'b0, cfg3}, 32'h0);
    check("R9 cfg4 after reset", {3'b0, cfg4}, 32'h0);
    wr(3'd0, 29'h07000000);
    rd(3'd6, got, first, tail);
    check("R8 flag after reset", {3'b0, got}, 32'h0000012A);

    done = 1'b1;
    summary();
  end
endmodule